// File: doc/BRIEF.md
# Fixed Off-Time Bridge Chopper Controller

This block sequences the four switches of one H-bridge that drives a motor winding. A direction bit chooses which diagonal of the bridge conducts. A two-bit level select chooses one of three current thresholds, or turns the bridge off. While the bridge conducts, an external comparator signals (through a synchronous trip flag) that the winding current has reached the threshold. The controller then switches off only the conducting high-side switch for a fixed number of cycles. The low-side switch stays on, so the current recirculates and decays slowly. After that interval the high side turns back on. This repeats for as long as the bridge stays enabled, which holds the average winding current near the chosen level.

The controller also guards the switch transitions. A change of direction, and every exit from the disabled state, passes through a dead interval with all four switches off. A blanking window after each high-side turn-on hides turn-on current spikes from the trip logic. A temperature code with hysteresis forces the bridge off when the die gets hot. The block drives a two-bit threshold code for the external reference generator. Every timing value is a count of clock cycles.

The states are named as follows:
- OFF: disabled; all switches off.
- DEAD: dead interval; all switches off.
- BLANK: diagonal on; trip ignored.
- ON: diagonal on; trip honoured.
- DECAY: high side off, low side on.

The transitions are named as follows:
- disable: from any state to OFF, when the level code is 11 or the thermal flag is set.
- reverse: from BLANK, ON or DECAY to DEAD, when the direction changes. A direction change inside DEAD reloads the dead interval.
- enable: OFF to DEAD.
- dead_done: DEAD to BLANK.
- blank_done: BLANK to ON.
- trip: ON to DECAY.
- decay_done: DECAY to BLANK.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: With direction 1, the conducting diagonal is high-side A plus low-side B, seen as {hs_a,ls_a,hs_b,ls_b}=1001. With direction 0, it is high-side B plus low-side A, seen as 0110.
- R2: The threshold code follows the level select: level 00 gives code 3 (full), level 01 gives code 2 (two-thirds), level 10 gives code 1 (one-third), and level 11 gives code 0. Level 11 also turns all four switches off from the next clock edge.
- R3: In ON, a trip turns off only the high side for exactly OFF_CYC cycles, and the low side stays on (0001 for direction 1, 0100 for direction 0). The high side then turns back on.
- R4: An OFF_CYC of zero behaves as an off-time of one cycle.
- R5: A change of direction, and any leaving of OFF, yields exactly DEAD_CYC cycles with all switches off before the new diagonal turns on. One diagonal never follows the other directly.
- R6: The trip flag is ignored for BLANK_CYC cycles after each high-side turn-on. With the trip flag held high, the high side stays on for BLANK_CYC+1 cycles.
- R7: A trip during DECAY, DEAD or OFF has no effect. It neither lengthens nor restarts any interval, and it does not turn on any switch.
- R8: A temperature code of HOT_CODE or above turns all switches off within two edges, and sets the threshold code to 0. Switching resumes only once the code is at or below COOL_CODE. It then resumes through a dead interval, so the output stays all-off for DEAD_CYC+1 cycles after the cool code is applied.
- R9: Reset leaves all switches off and the threshold code 0. Internally, reset behaves as direction 1 with level 11 applied, so the bridge stays off until a different level is applied.
- R10: The switch enables are registered. A high side and a low side of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_i | input | 1 | Current direction select |
| lvl_i | input | 2 | Current level select; 11 disables the bridge |
| trip_i | input | 1 | Synchronous comparator trip flag |
| temp_i | input | TEMP_W | Die temperature code |
| hs_a_o | output | 1 | High-side switch enable, leg A |
| ls_a_o | output | 1 | Low-side switch enable, leg A |
| hs_b_o | output | 1 | High-side switch enable, leg B |
| ls_b_o | output | 1 | Low-side switch enable, leg B |
| thr_sel_o | output | 2 | Threshold code for the external reference (3 full, 2 two-thirds, 1 one-third, 0 none) |

## Verification
The assertions check the following on every cycle:
- neither leg ever has both of its switches on;
- one diagonal never follows the other without an all-off cycle between them;
- level 11 blanks the outputs and the threshold code on the next edge;
- a hot code blanks the outputs two edges later;
- the threshold code tracks the level select while the die is cool.

Only the bench scenarios can show the exact lengths of the dead, blanking and off-time intervals. They also show that trips held through the dead, decay and disabled phases change nothing, that the zero off-time is clamped, and that the thermal flag holds between the two temperature codes.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DEAD,
        ST_BLANK,
        ST_ON,
        ST_DECAY
    } chop_state_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } drv_t;

    localparam logic [1:0] LVL_FULL  = 2'b00;
    localparam logic [1:0] LVL_TWO3  = 2'b01;
    localparam logic [1:0] LVL_ONE3  = 2'b10;
    localparam logic [1:0] LVL_OFF   = 2'b11;

    localparam logic [1:0] THR_NONE  = 2'd0;
    localparam logic [1:0] THR_ONE3  = 2'd1;
    localparam logic [1:0] THR_TWO3  = 2'd2;
    localparam logic [1:0] THR_FULL  = 2'd3;

    localparam drv_t DRV_ALL_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

    function automatic logic [1:0] thr_of(input logic [1:0] lvl);
        logic [1:0] code;
        unique case (lvl)
            LVL_FULL: code = THR_FULL;
            LVL_TWO3: code = THR_TWO3;
            LVL_ONE3: code = THR_ONE3;
            default:  code = THR_NONE;
        endcase
        return code;
    endfunction

    // Diagonal for a direction; keep_hs=0 yields the slow-decay pattern.
    function automatic drv_t diag_of(input logic dir, input logic keep_hs);
        drv_t d;
        d = DRV_ALL_OFF;
        if (dir) begin
            d.hs_a = keep_hs;
            d.ls_b = 1'b1;
        end else begin
            d.hs_b = keep_hs;
            d.ls_a = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/chop_thermal.sv
`timescale 1ns/1ps
module chop_thermal #(
    parameter int TEMP_W    = 8,
    parameter int HOT_CODE  = 170,
    parameter int COOL_CODE = 145
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hot_o
);

    localparam logic [TEMP_W-1:0] HOT_V  = TEMP_W'(HOT_CODE);
    localparam logic [TEMP_W-1:0] COOL_V = TEMP_W'(COOL_CODE);

    logic hot_q;
    logic hot_n;

    always_comb begin
        if (hot_q) begin
            hot_n = (temp_i > COOL_V);
        end else begin
            hot_n = (temp_i >= HOT_V);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else begin
            hot_q <= hot_n;
        end
    end

    assign hot_o = hot_q;

endmodule

// File: rtl/chop_timer.sv
`timescale 1ns/1ps
module chop_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/chop_fsm.sv
`timescale 1ns/1ps
module chop_fsm
    import chop_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DEAD_LD  = 3,
    parameter int BLANK_LD = 2,
    parameter int OFF_LD   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic [1:0]       lvl_i,
    input  logic             trip_i,
    input  logic             hot_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output drv_t             drv_o,
    output logic [1:0]       thr_o
);

    localparam logic [CNT_W-1:0] DEAD_V  = CNT_W'(DEAD_LD);
    localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_LD);
    localparam logic [CNT_W-1:0] OFF_V   = CNT_W'(OFF_LD);

    chop_state_e state_q, state_n;
    logic        dir_q;
    logic        off_req;
    logic        dir_chg;
    drv_t        drv_q;
    logic [1:0]  thr_q;

    assign off_req = hot_i || (lvl_i == LVL_OFF);
    assign dir_chg = (dir_i != dir_q);

    // Next-state and timer-load decisions
    always_comb begin
        state_n    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (off_req) begin
            state_n = ST_OFF;
        end else if (dir_chg && (state_q != ST_OFF)) begin
            state_n    = ST_DEAD;
            tmr_load_o = 1'b1;
            tmr_val_o  = DEAD_V;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_n    = ST_DEAD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = DEAD_V;
                end
                ST_DEAD: begin
                    if (tmr_zero_i) begin
                        state_n    = ST_BLANK;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = BLANK_V;
                    end
                end
                ST_BLANK: begin
                    if (tmr_zero_i) begin
                        state_n = ST_ON;
                    end
                end
                ST_ON: begin
                    if (trip_i) begin
                        state_n    = ST_DECAY;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = OFF_V;
                    end
                end
                ST_DECAY: begin
                    if (tmr_zero_i) begin
                        state_n    = ST_BLANK;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = BLANK_V;
                    end
                end
                default: begin
                    state_n = ST_OFF;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dir_q   <= 1'b1;
        end else begin
            state_q <= state_n;
            dir_q   <= dir_i;
        end
    end

    // Registered outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= DRV_ALL_OFF;
            thr_q <= THR_NONE;
        end else begin
            unique case (state_n)
                ST_BLANK, ST_ON: drv_q <= diag_of(dir_i, 1'b1);
                ST_DECAY:        drv_q <= diag_of(dir_i, 1'b0);
                default:         drv_q <= DRV_ALL_OFF;
            endcase
            thr_q <= off_req ? THR_NONE : thr_of(lvl_i);
        end
    end

    assign drv_o = drv_q;
    assign thr_o = thr_q;

endmodule

// File: rtl/chop_bridge_ctrl.sv
`timescale 1ns/1ps
module chop_bridge_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 2500,
    parameter int DEAD_CYC  = 250,
    parameter int BLANK_CYC = 125,
    parameter int TEMP_W    = 8,
    parameter int HOT_CODE  = 170,
    parameter int COOL_CODE = 145
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_i,
    input  logic [1:0]        lvl_i,
    input  logic              trip_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hs_a_o,
    output logic              ls_a_o,
    output logic              hs_b_o,
    output logic              ls_b_o,
    output logic [1:0]        thr_sel_o
);

    localparam int OFF_EFF   = (OFF_CYC   < 1) ? 1 : OFF_CYC;
    localparam int DEAD_EFF  = (DEAD_CYC  < 1) ? 1 : DEAD_CYC;
    localparam int BLANK_EFF = (BLANK_CYC < 1) ? 1 : BLANK_CYC;
    localparam int MAX_A     = (OFF_EFF > DEAD_EFF) ? OFF_EFF : DEAD_EFF;
    localparam int MAX_CYC   = (MAX_A > BLANK_EFF) ? MAX_A : BLANK_EFF;
    localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             hot;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    drv_t             drv;

    chop_thermal #(
        .TEMP_W   (TEMP_W),
        .HOT_CODE (HOT_CODE),
        .COOL_CODE(COOL_CODE)
    ) u_thermal (
        .clk   (clk),
        .rst_n (rst_n),
        .temp_i(temp_i),
        .hot_o (hot)
    );

    chop_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(tmr_load),
        .val_i (tmr_val),
        .zero_o(tmr_zero)
    );

    chop_fsm #(
        .CNT_W   (CNT_W),
        .DEAD_LD (DEAD_EFF - 1),
        .BLANK_LD(BLANK_EFF - 1),
        .OFF_LD  (OFF_EFF - 1)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_i),
        .lvl_i     (lvl_i),
        .trip_i    (trip_i),
        .hot_i     (hot),
        .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load),
        .tmr_val_o (tmr_val),
        .drv_o     (drv),
        .thr_o     (thr_sel_o)
    );

    assign hs_a_o = drv.hs_a;
    assign ls_a_o = drv.ls_a;
    assign hs_b_o = drv.hs_b;
    assign ls_b_o = drv.ls_b;

endmodule

// File: rtl/chop_bridge_ctrl_chk.sv
`timescale 1ns/1ps
module chop_bridge_ctrl_chk #(
    parameter int TEMP_W    = 8,
    parameter int HOT_CODE  = 170,
    parameter int COOL_CODE = 145
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_i,
    input logic [1:0]        lvl_i,
    input logic              trip_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic              hs_a_o,
    input logic              ls_a_o,
    input logic              hs_b_o,
    input logic              ls_b_o,
    input logic [1:0]        thr_sel_o
);

    logic all_off;
    assign all_off = !(hs_a_o || ls_a_o || hs_b_o || ls_b_o);

    assert_leg_a_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o));

    assert_leg_b_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o));

    assert_no_direct_reverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hs_a_o || ls_b_o) |-> !(hs_b_o || ls_a_o));

    assert_level_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i == 2'b11) |=> (all_off && thr_sel_o == 2'd0));

    assert_hot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i >= TEMP_W'(HOT_CODE)) |-> ##2 all_off);

    assert_thr_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(temp_i) <= TEMP_W'(COOL_CODE)) && (lvl_i != 2'b11))
        |=> (thr_sel_o == 2'd3 - $past(lvl_i)));

    // dir_i and trip_i are part of the observed interface but no property needs them.
    logic unused_ok;
    assign unused_ok = dir_i ^ trip_i;

endmodule

bind chop_bridge_ctrl chop_bridge_ctrl_chk #(
    .TEMP_W   (TEMP_W),
    .HOT_CODE (HOT_CODE),
    .COOL_CODE(COOL_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_i    (dir_i),
    .lvl_i    (lvl_i),
    .trip_i   (trip_i),
    .temp_i   (temp_i),
    .hs_a_o   (hs_a_o),
    .ls_a_o   (ls_a_o),
    .hs_b_o   (hs_b_o),
    .ls_b_o   (ls_b_o),
    .thr_sel_o(thr_sel_o)
);

// File: tb/tb_chop_bridge_ctrl.sv
`timescale 1ns/1ps
module tb_chop_bridge_ctrl;

    localparam int DEAD  = 4;
    localparam int BLANK = 3;
    localparam int OFFT  = 6;
    localparam int HOT   = 170;
    localparam int COOL  = 145;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b1;
    logic [1:0] lvl = 2'b11;
    logic       trip = 1'b0;
    logic [7:0] temp = 8'd25;

    logic hs_a, ls_a, hs_b, ls_b;
    logic [1:0] thr;
    logic zhs_a, zls_a, zhs_b, zls_b;
    logic [1:0] zthr;
    logic [3:0] out, out_z;

    int  n_chk = 0;
    int  n_fail = 0;
    int  leg_bad = 0;
    bit  finished = 1'b0;
    int  n;

    always #4 clk = ~clk;

    chop_bridge_ctrl #(
        .OFF_CYC(OFFT), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK),
        .TEMP_W(8), .HOT_CODE(HOT), .COOL_CODE(COOL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dir_i(dir), .lvl_i(lvl), .trip_i(trip),
        .temp_i(temp), .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b),
        .ls_b_o(ls_b), .thr_sel_o(thr)
    );

    chop_bridge_ctrl #(
        .OFF_CYC(0), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK),
        .TEMP_W(8), .HOT_CODE(HOT), .COOL_CODE(COOL)
    ) dut_z (
        .clk(clk), .rst_n(rst_n), .dir_i(dir), .lvl_i(lvl), .trip_i(trip),
        .temp_i(temp), .hs_a_o(zhs_a), .ls_a_o(zls_a), .hs_b_o(zhs_b),
        .ls_b_o(zls_b), .thr_sel_o(zthr)
    );

    assign out   = {hs_a, ls_a, hs_b, ls_b};
    assign out_z = {zhs_a, zls_a, zhs_b, zls_b};

    function automatic logic [3:0] diag(input bit d);
        return d ? 4'b1001 : 4'b0110;
    endfunction

    function automatic logic [3:0] decay(input bit d);
        return d ? 4'b0001 : 4'b0100;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_len(input bit z, input logic [3:0] pat, output int len);
        len = 0;
        while (((z ? out_z : out) == pat) && len < 2000) begin
            len++;
            tick();
        end
    endtask

    task automatic finish_run();
        chk(leg_bad == 0, "R10 leg overlap count", leg_bad, 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // R10: monitor both instances on every cycle
    always @(negedge clk) begin
        if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b) || (zhs_a && zls_a) || (zhs_b && zls_b)))
            leg_bad++;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) tick();
        chk(out == 4'b0000, "R9 outputs in reset", out, 0);
        chk(thr == 2'd0, "R9 threshold code in reset", thr, 0);
        rst_n = 1'b1;
        trip  = 1'b1;
        repeat (5) tick();
        chk(out == 4'b0000, "R9/R7 off after reset with trip", out, 0);
        chk(thr == 2'd0, "R9 threshold code after reset", thr, 0);
        trip = 1'b0;

        // R5: enable passes through dead interval; R1/R2 diagonal and code
        lvl = 2'b00;
        tick();
        run_len(1'b0, 4'b0000, n);
        chk(n == DEAD, "R5 enable dead length", n, DEAD);
        chk(out == diag(1'b1), "R1 direction 1 diagonal", out, diag(1'b1));
        chk(thr == 2'd3, "R2 full threshold code", thr, 3);

        // R3/R6/R7: trip held high, chopping repeats with fixed lengths
        trip = 1'b1;
        for (int i = 0; i < 3; i++) begin
            run_len(1'b0, diag(1'b1), n);
            chk(n == BLANK + 1, "R6 blanking on-run", n, BLANK + 1);
            run_len(1'b0, decay(1'b1), n);
            chk(n == OFFT, "R3/R7 off-time with trip held", n, OFFT);
        end
        chk(out == diag(1'b1), "R3 high side returns", out, diag(1'b1));
        trip = 1'b0;
        repeat (8) tick();

        // R5/R7: direction change with trip held through the dead interval
        dir  = 1'b0;
        trip = 1'b1;
        tick();
        run_len(1'b0, 4'b0000, n);
        chk(n == DEAD, "R5/R7 reverse dead length", n, DEAD);
        chk(out == diag(1'b0), "R1 direction 0 diagonal", out, diag(1'b0));
        run_len(1'b0, diag(1'b0), n);
        chk(n == BLANK + 1, "R6 blanking direction 0", n, BLANK + 1);
        run_len(1'b0, decay(1'b0), n);
        chk(n == OFFT, "R3 off-time direction 0", n, OFFT);
        trip = 1'b0;
        repeat (8) tick();

        // R1/R2: sweep direction and level
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < 4; l++) begin
                logic [3:0] exp_o;
                dir = d[0];
                lvl = l[1:0];
                repeat (DEAD + BLANK + 4) tick();
                exp_o = (l == 3) ? 4'b0000 : diag(d[0]);
                chk(out == exp_o, "R1/R2 sweep switches", out, exp_o);
                chk(thr == 2'(3 - l), "R2 sweep threshold code", thr, 3 - l);
                chk(out_z == exp_o, "R1/R2 sweep switches clamp instance", out_z, exp_o);
            end
        end

        // R4: zero off-time clamps to one cycle
        dir = 1'b1;
        lvl = 2'b00;
        repeat (DEAD + BLANK + 4) tick();
        trip = 1'b1;
        tick();
        run_len(1'b1, decay(1'b1), n);
        chk(n == 1, "R4 zero off-time clamp", n, 1);
        trip = 1'b0;
        repeat (20) tick();

        // R8: thermal shutdown with hysteresis
        temp = 8'(HOT - 1);
        repeat (5) tick();
        chk(out == diag(1'b1), "R8 below hot code stays on", out, diag(1'b1));
        temp = 8'(HOT);
        tick();
        tick();
        chk(out == 4'b0000, "R8 off at hot code", out, 0);
        chk(thr == 2'd0, "R8 threshold code when hot", thr, 0);
        temp = 8'(COOL + 5);
        repeat (10) tick();
        chk(out == 4'b0000, "R8 hysteresis hold", out, 0);
        temp = 8'(COOL);
        tick();
        run_len(1'b0, 4'b0000, n);
        chk(n == DEAD + 1, "R8 resume through dead", n, DEAD + 1);
        chk(out == diag(1'b1), "R8 resumed diagonal", out, diag(1'b1));
        temp = 8'd200;
        repeat (4) tick();
        temp = 8'(COOL + 1);
        repeat (10) tick();
        chk(out == 4'b0000, "R8 cool+1 stays off", out, 0);
        temp = 8'd25;
        repeat (12) tick();

        finish_run();
    end

endmodule